// File: doc/BRIEF.md
# Load-Multiple Transfer Sequencer

This block controls the data phase of a processor's load-multiple instruction. A one-cycle `start` pulse brings in a register mask, a base address and a writeback enable. The block then works through every selected register. It fetches one word per cycle over a word-wide read interface. Each fetched word goes to the register-file write port one cycle later, so the write of one word overlaps the fetch of the next.

The sequence has three kinds of cycle. It opens with one address cycle that makes no request. A run of fetch cycles follows, and the first of them also drives the updated base onto the base writeback port. The sequence closes with one internal cycle that makes no new fetch and writes the last word. Registers go in ascending index order, and the program counter (the highest index) therefore always comes last. An abort on a fetch does not shorten the sequence. It blocks that register write and every one after it, and the closing cycle puts the base register back. When the program counter is loaded cleanly, a one-cycle flush tells the front end to drop its prefetched instructions.

Top module: `ldm_seq`

## Requirements
- R1: While the block is idle, a `start` with a nonzero `reg_mask` begins a sequence. The next cycle is an address cycle: `mem_req`, `rf_we`, `base_we` and `done` are all 0. The first fetch follows in the cycle after it.
- R2: The k-th fetch (k from 0) drives `mem_req`=1 and `mem_addr` = base + 4k. `mem_seq` is 0 for k=0 and 1 for every later fetch. There is exactly one fetch per set mask bit.
- R3: In the first fetch cycle, `base_we` equals the writeback enable and `base_wdata` = base + 4 × (number of set mask bits). No other fetch cycle asserts `base_we`.
- R4: The word read in fetch k is written in the following cycle. `rf_we`=1, `rf_wdata` is the `mem_rdata` of that fetch, and `rf_waddr` is the k-th lowest set bit of the mask.
- R5: After the last fetch, one final cycle has `mem_req`=0 and `done`=1, and it carries the write of the last word. A mask with N set bits takes N+2 cycles from the address cycle through the final cycle, so a single-bit mask takes 3.
- R6: `mem_abort` is sampled only during fetches. Once it has been sampled, the sequence still runs to its full length. The aborted fetch and every later fetch produce no `rf_we`.
- R7: If an abort occurred, the final cycle asserts `base_we`. `base_wdata` is the modified base when writeback is enabled and the original base otherwise. Without an abort, the final cycle leaves `base_we` at 0.
- R8: Register 15 is always the last register fetched. After an abort, no write to register 15 takes place.
- R9: `flush` is 1 for exactly the final cycle when bit 15 of the mask is set and no abort occurred. Otherwise it stays 0.
- R10: A `start` with an all-zero mask while idle raises `err` for the following cycle only. It causes no fetch, no write and no `done`.
- R11: A `start` that arrives while a sequence is in progress has no effect. The block returns to idle after the final cycle.
- R12: During and directly after reset, `mem_req`, `rf_we`, `base_we`, `flush`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only while idle) |
| reg_mask | input | 16 | Register selection mask, bit i selects register i |
| base_addr | input | 32 | Word-aligned start address |
| wb_en | input | 1 | Write the updated base register |
| mem_addr | output | 32 | Read address |
| mem_req | output | 1 | Read request this cycle |
| mem_seq | output | 1 | Read follows the previous one sequentially |
| mem_rdata | input | 32 | Read data, valid in the request cycle |
| mem_abort | input | 1 | Read failed, valid in the request cycle |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| base_we | output | 1 | Base register write enable |
| base_wdata | output | 32 | Base register write value |
| flush | output | 1 | Invalidate the instruction pipeline |
| done | output | 1 | Final cycle of a transfer |
| err | output | 1 | Empty mask rejected |

## Verification
The assertions check the local timing rules on every cycle. They check that each sequential fetch steps the address by one word, that a register write always follows a fetch, and that no write occurs once an abort has been seen. They also check that flush appears only together with an abort-free `done` and that register 15 is written only in the final cycle. Only the bench scenarios can show the rules that span a whole transfer: the base value that is written and the value restored after an abort, the matching of each write index and word to the mask and to the fetched data, the exact sequence length for a given mask, and the rejection of empty-mask and mid-transfer starts.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_FETCH = 2'd2,
    ST_LAST  = 2'd3
  } ldm_state_e;
endpackage

// File: rtl/ldm_mask_scan.sv
module ldm_mask_scan #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG),
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0]  mask,
  output logic [IDX_W-1:0] low_idx,
  output logic             one_left,
  output logic [CNT_W-1:0] bit_count
);
  // lowest set bit: scan downward so the lowest index wins
  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) low_idx = IDX_W'(i);
    end
  end

  always_comb begin
    bit_count = '0;
    for (int i = 0; i < NREG; i++) begin
      bit_count = bit_count + CNT_W'(mask[i]);
    end
  end

  assign one_left = (bit_count == CNT_W'(1));
endmodule

// File: rtl/ldm_addr_gen.sv
module ldm_addr_gen #(
  parameter int AW    = 32,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [AW-1:0]    base_in,
  input  logic [CNT_W-1:0] count_in,
  output logic [AW-1:0]    cur_addr,
  output logic [AW-1:0]    orig_base,
  output logic [AW-1:0]    mod_base
);
  localparam int WORD_BYTES = 4;

  logic [AW-1:0] span;
  assign span = AW'(count_in) * AW'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr  <= '0;
      orig_base <= '0;
      mod_base  <= '0;
    end else if (load) begin
      cur_addr  <= base_in;
      orig_base <= base_in;
      mod_base  <= base_in + span;
    end else if (step) begin
      cur_addr  <= cur_addr + AW'(WORD_BYTES);
    end
  end
endmodule

// File: rtl/ldm_wr_stage.sv
module ldm_wr_stage #(
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             capture,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [DW-1:0]    data_in,
  input  logic             abort_in,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             aborted
);
  logic pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v   <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      aborted  <= 1'b0;
    end else begin
      pend_v <= capture;
      if (capture) begin
        rf_waddr <= idx_in;
        rf_wdata <= data_in;
      end
      if (clear)                     aborted <= 1'b0;
      else if (capture && abort_in)  aborted <= 1'b1;
    end
  end

  // the fault flag is updated on the same edge that captures the word,
  // so the faulting word's own write is blocked too
  assign rf_we = pend_v & ~aborted;
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
  import ldm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NREG-1:0]  reg_mask,
  input  logic [AW-1:0]    base_addr,
  input  logic             wb_en,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_req,
  output logic             mem_seq,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_abort,
  output logic             rf_we,
  output logic [IDX_W-1:0] rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             base_we,
  output logic [AW-1:0]    base_wdata,
  output logic             flush,
  output logic             done,
  output logic             err
);
  ldm_state_e      state;
  logic [NREG-1:0] rem_q;
  logic            wb_q, pc_q, first_q, err_q;

  logic            accept;
  logic [IDX_W-1:0] scan_idx;
  logic            scan_last;
  logic [CNT_W-1:0] rem_cnt, start_cnt;
  logic            unused_start_last;
  logic [IDX_W-1:0] unused_start_idx;
  logic [AW-1:0]   cur_addr, orig_base, mod_base;
  logic            aborted;
  logic            fetching;

  assign accept   = (state == ST_IDLE) && start && (reg_mask != '0);
  assign fetching = (state == ST_FETCH);

  // scanner over the remaining mask drives the fetch order
  ldm_mask_scan #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan_rem (
    .mask(rem_q), .low_idx(scan_idx), .one_left(scan_last), .bit_count(rem_cnt)
  );

  // scanner over the incoming mask gives the word count for base update
  ldm_mask_scan #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_scan_in (
    .mask(reg_mask), .low_idx(unused_start_idx), .one_left(unused_start_last),
    .bit_count(start_cnt)
  );

  ldm_addr_gen #(.AW(AW), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst(rst), .load(accept), .step(fetching),
    .base_in(base_addr), .count_in(start_cnt),
    .cur_addr(cur_addr), .orig_base(orig_base), .mod_base(mod_base)
  );

  ldm_wr_stage #(.DW(DW), .IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst(rst), .clear(accept), .capture(fetching),
    .idx_in(scan_idx), .data_in(mem_rdata), .abort_in(mem_abort),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .aborted(aborted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rem_q   <= '0;
      wb_q    <= 1'b0;
      pc_q    <= 1'b0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= (state == ST_IDLE) && start && (reg_mask == '0);
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_ADDR;
          rem_q   <= reg_mask;
          wb_q    <= wb_en;
          pc_q    <= reg_mask[NREG-1];
          first_q <= 1'b1;
        end
        ST_ADDR: state <= ST_FETCH;
        ST_FETCH: begin
          rem_q[scan_idx] <= 1'b0;
          first_q         <= 1'b0;
          if (scan_last || rem_cnt == '0) state <= ST_LAST;
        end
        ST_LAST: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req    = fetching;
  assign mem_seq    = fetching && !first_q;
  assign mem_addr   = cur_addr;
  assign done       = (state == ST_LAST);
  assign err        = err_q;
  assign flush      = done && pc_q && !aborted;
  assign base_we    = (fetching && first_q && wb_q) || (done && aborted);
  assign base_wdata = (done && !wb_q) ? orig_base : mod_base;
endmodule

// File: rtl/ldm_seq_chk.sv
module ldm_seq_chk #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_req,
  input logic             mem_seq,
  input logic             mem_abort,
  input logic             rf_we,
  input logic [IDX_W-1:0] rf_waddr,
  input logic             flush,
  input logic             done,
  input logic             err
);
  logic ab_seen;
  always_ff @(posedge clk) begin
    if (rst)                       ab_seen <= 1'b0;
    else if (done)                 ab_seen <= 1'b0;
    else if (mem_req && mem_abort) ab_seen <= 1'b1;
  end

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_seq |-> $past(mem_req) && mem_addr == $past(mem_addr) + AW'(4));

  p_write_after_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> $past(mem_req));

  p_final_no_req_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  p_no_write_after_abort_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !ab_seen);

  p_pc_written_last_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we && rf_waddr == IDX_W'(NREG - 1) |-> done);

  p_flush_clean_done_r9: assert property (@(posedge clk) disable iff (rst)
    flush |-> done && !ab_seen);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    err |-> !mem_req && !done && !rf_we);
endmodule

bind ldm_seq ldm_seq_chk #(.AW(AW), .NREG(NREG)) u_chk (.*);

// File: tb/ldm_seq_test.sv
module ldm_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [31:0] base_addr = '0;
  logic        wb_en = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_req, mem_seq;
  logic [31:0] mem_rdata = '0;
  logic        mem_abort = 1'b0;
  logic        rf_we;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        base_we;
  logic [31:0] base_wdata;
  logic        flush, done, err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ldm_seq uut (
    .clk(clk), .rst(rst), .start(start), .reg_mask(reg_mask),
    .base_addr(base_addr), .wb_en(wb_en), .mem_addr(mem_addr),
    .mem_req(mem_req), .mem_seq(mem_seq), .mem_rdata(mem_rdata),
    .mem_abort(mem_abort), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .base_we(base_we), .base_wdata(base_wdata),
    .flush(flush), .done(done), .err(err)
  );

  function automatic logic [31:0] word_at(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  function automatic int popc(logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one whole transfer; abort_at = -1 means no abort
  task automatic run_tx(logic [15:0] m, logic [31:0] b, bit wb, int abort_at, bit stray);
    int idx[16];
    int n;
    bit ab;
    logic [31:0] modb;
    n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin idx[n] = i; n++; end
    modb = b + 32'(4 * n);
    @(negedge clk);
    start = 1'b1; reg_mask = m; base_addr = b; wb_en = wb;
    @(negedge clk);
    start = 1'b0; reg_mask = $urandom; base_addr = $urandom; wb_en = ~wb;
    if (n == 0) begin
      chk(err == 1'b1, "R10 err pulse", err, 1);
      chk(!mem_req && !done && !rf_we, "R10 no activity", mem_req, 0);
      @(negedge clk);
      chk(err == 1'b0, "R10 err one cycle", err, 0);
      chk(!mem_req && !done, "R10 still idle", mem_req, 0);
      return;
    end
    chk(!mem_req && !rf_we && !base_we && !done, "R1 address cycle",
        {mem_req, rf_we, base_we, done}, 0);
    for (int c = 0; c <= n; c++) begin
      @(negedge clk);
      ab = (abort_at >= 0) && (abort_at <= c - 1);
      start = stray && (c == 1);
      if (c < n) begin
        mem_rdata = word_at(mem_addr);
        mem_abort = (c == abort_at);
        chk(mem_req == 1'b1, "R2 fetch request", mem_req, 1);
        chk(mem_addr == b + 32'(4 * c), "R2 fetch address", mem_addr, b + 32'(4 * c));
        chk(mem_seq == (c > 0), "R2 sequential flag", mem_seq, (c > 0));
        chk(done == 1'b0, "R5 no early done", done, 0);
        chk(base_we == (c == 0 && wb), "R3 base write enable", base_we, (c == 0 && wb));
        if (c == 0 && wb) chk(base_wdata == modb, "R3 modified base", base_wdata, modb);
      end else begin
        mem_abort = 1'b0;
        chk(mem_req == 1'b0 && done == 1'b1, "R5 final cycle", {mem_req, done}, 2'b01);
        chk(base_we == ab, "R7 restore enable", base_we, ab);
        if (ab) chk(base_wdata == (wb ? modb : b), "R7 restore value",
                    base_wdata, wb ? modb : b);
        chk(flush == (m[15] && !ab), "R9 flush", flush, (m[15] && !ab));
      end
      if (c == 0) begin
        chk(rf_we == 1'b0, "R4 no write in first fetch", rf_we, 0);
      end else if (ab) begin
        chk(rf_we == 1'b0, "R6 write suppressed", rf_we, 0);
      end else begin
        chk(rf_we == 1'b1, "R4 write enable", rf_we, 1);
        chk(rf_waddr == 4'(idx[c-1]), "R4 write index", rf_waddr, idx[c-1]);
        chk(rf_wdata == word_at(b + 32'(4 * (c - 1))), "R4 write data",
            rf_wdata, word_at(b + 32'(4 * (c - 1))));
        if (rf_waddr == 4'd15) chk(c == n, "R8 pc written last", c, n);
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(!mem_req && !done && !rf_we && !base_we, "R11 idle after transfer",
        {mem_req, done, rf_we, base_we}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!mem_req && !rf_we && !base_we && !flush && !done && !err, "R12 in reset",
        {mem_req, rf_we, base_we, flush, done, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !rf_we && !base_we && !flush && !done && !err, "R12 after reset",
        {mem_req, rf_we, base_we, flush, done, err}, 0);
    // directed corners
    run_tx(16'h0001, 32'h0000_1000, 1'b1, -1, 1'b0); // R5 minimum sequence
    run_tx(16'h0000, 32'h0000_2000, 1'b1, -1, 1'b0); // R10 empty mask
    run_tx(16'h8000, 32'h0000_3000, 1'b0, -1, 1'b1); // R9 pc alone, R11 stray start
    run_tx(16'h8000, 32'h0000_3100, 1'b1,  0, 1'b0); // R8 abort keeps pc
    run_tx(16'hFFFF, 32'h0000_4000, 1'b1, -1, 1'b1); // full mask
    run_tx(16'h8421, 32'h0000_5000, 1'b0,  3, 1'b0); // R6 abort on last fetch
    run_tx(16'h00F0, 32'h0000_6000, 1'b1,  1, 1'b0); // R7 mid abort
    // constrained random
    for (int t = 0; t < 60; t++) begin
      logic [15:0] m;
      int n, ab_at;
      m = 16'($urandom);
      case ($urandom % 6)
        0: m = '0;
        1: m = 16'(1) << ($urandom % 16);
        2: m[15] = 1'b1;
        default: ;
      endcase
      n = popc(m);
      ab_at = (n > 0 && ($urandom % 3 == 0)) ? int'($urandom % n) : -1;
      run_tx(m, $urandom & 32'h0FFF_FFFC, 1'($urandom), ab_at, 1'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule